// File: doc/BRIEF.md
# Programmable UART Frame Transmitter

This block turns a byte written into its holding register into an asynchronous serial frame on a single output line. The line rests high. A frame opens with a low start bit and carries five to eight data bits, least significant bit first. An optional even or odd parity bit follows, and the frame closes with one, one and a half, or two high stop periods. The one-and-a-half setting applies only when the word is five bits long.

Bit timing comes from an internal 16x tick. A 16-bit divisor counter produces one tick every `divisor` clocks, and every bit period is sixteen ticks long. A holding register sits in front of a separate shift register, so the next byte can be written while the current frame is still on the line. Two flags report the state of the transmit path. One shows that the holding register is empty. The other shows that the whole transmitter is empty.

Top module: `uart_frame_tx`

## Requirements
- R1: The line is 1 when idle. A frame is sent as a 0 start bit, then the data bits with the least significant bit first, then the parity bit if enabled, then the stop period at level 1.
- R2: `cfg_wlen` selects the word length: 0→5, 1→6, 2→7, 3→8 data bits. Bits of `wr_data` above the word length are never sent.
- R3: When `cfg_par_en`=1 a parity bit is sent. It is computed over the active data bits only. With `cfg_par_odd`=0 the number of ones across data and parity is even; with `cfg_par_odd`=1 it is odd. When `cfg_par_en`=0 no parity bit is sent.
- R4: The stop period lasts 16 ticks when `cfg_stop2`=0. When `cfg_stop2`=1 it lasts 32 ticks, except with `cfg_wlen`=0, where it lasts 24 ticks.
- R5: A nonzero `divisor` gives one tick every `divisor` clocks. Each start, data and parity bit lasts 16 ticks. A divisor of 0 stops the ticks, and a frame in progress freezes in its current bit.
- R6: `hold_empty` goes low in the clock after a write. It returns high once the byte moves into the shift register, which happens one clock after the write when the transmitter is idle, or one clock after the current stop period ends. The next start bit follows at that point.
- R7: `tx_empty` is high only when the holding register is empty and the final stop period has finished.
- R8: The framing inputs are sampled when a byte is loaded into the shift register. Changing them during a frame has no effect on that frame.
- R9: After reset, `txd`=1, `hold_empty`=1 and `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_wlen | input | 2 | Word length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Long stop period select (2, or 1.5 with 5-bit words) |
| divisor | input | 16 | Clocks per 16x tick; 0 stops the tick |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding and shift registers empty, last stop done |

## Verification
The main risk is a wrong sub-bit tick count or bit index. Either one moves every later bit boundary, so mid-bit sampling sees a wrong data, parity or stop level within one bit period of the fault. A wrong stop length or a stuck state shows up as the wrong interval between the start edge and the rise of `tx_empty`, and that interval is measured with a tolerance of one tick. Faults in the holding-register flags appear at the flag pins in the clock after a write, or at the frame boundary where the next byte should load.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/uftx_baud_gen.sv
module uftx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        tick  = 1'b0;
        if (divisor == '0) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt >= DIV_W'(divisor - DIV_W'(1))) begin
            tick      = 1'b1;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > DIV_W'(1)) |=> (!tick || divisor != $past(divisor)));
endmodule

// File: rtl/uftx_serializer.sv
module uftx_serializer #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);
    import uftx_pkg::*;

    localparam int CNT_W  = $clog2(2 * OVS);
    localparam int BIDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] STOP1_END = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] STOPH_END = CNT_W'(OVS + OVS / 2 - 1);
    localparam logic [CNT_W-1:0] STOP2_END = CNT_W'(2 * OVS - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic [DATA_W-1:0] shreg;
        logic [BIDX_W-1:0] bidx;
        logic [BIDX_W-1:0] last_idx;
        logic [CNT_W-1:0]  tcnt;
        logic [CNT_W-1:0]  stop_end;
        logic              par_en;
        logic              par_bit;
    } ser_t;

    ser_t cur_q, nxt_d;

    logic              load;
    logic [BIDX_W-1:0] new_last;
    logic [DATA_W-1:0] act_mask;

    always_comb begin
        new_last = BIDX_W'(4) + BIDX_W'(cfg_wlen);
        for (int i = 0; i < DATA_W; i++) begin
            act_mask[i] = (i <= int'(new_last));
        end
    end

    always_comb begin
        nxt_d = cur_q;
        load  = (cur_q.state == ST_IDLE) && cur_q.hold_full;

        if (wr_en) begin
            nxt_d.hold      = wr_data;
            nxt_d.hold_full = 1'b1;
        end else if (load) begin
            nxt_d.hold_full = 1'b0;
        end

        case (cur_q.state)
            ST_IDLE: begin
                if (load) begin
                    nxt_d.state    = ST_START;
                    nxt_d.shreg    = cur_q.hold;
                    nxt_d.tcnt     = '0;
                    nxt_d.bidx     = '0;
                    nxt_d.last_idx = new_last;
                    nxt_d.par_en   = cfg_par_en;
                    nxt_d.par_bit  = (^(cur_q.hold & act_mask)) ^ cfg_par_odd;
                    if (!cfg_stop2)          nxt_d.stop_end = STOP1_END;
                    else if (cfg_wlen == '0) nxt_d.stop_end = STOPH_END;
                    else                     nxt_d.stop_end = STOP2_END;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cur_q.tcnt == BIT_LAST) begin
                        nxt_d.tcnt  = '0;
                        nxt_d.state = ST_DATA;
                    end else begin
                        nxt_d.tcnt = cur_q.tcnt + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (cur_q.tcnt == BIT_LAST) begin
                        nxt_d.tcnt  = '0;
                        nxt_d.shreg = cur_q.shreg >> 1;
                        if (cur_q.bidx == cur_q.last_idx) begin
                            nxt_d.state = cur_q.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            nxt_d.bidx = cur_q.bidx + BIDX_W'(1);
                        end
                    end else begin
                        nxt_d.tcnt = cur_q.tcnt + CNT_W'(1);
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (cur_q.tcnt == BIT_LAST) begin
                        nxt_d.tcnt  = '0;
                        nxt_d.state = ST_STOP;
                    end else begin
                        nxt_d.tcnt = cur_q.tcnt + CNT_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (cur_q.tcnt == cur_q.stop_end) begin
                        nxt_d.tcnt  = '0;
                        nxt_d.state = ST_IDLE;
                    end else begin
                        nxt_d.tcnt = cur_q.tcnt + CNT_W'(1);
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        case (cur_q.state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = cur_q.shreg[0];
            ST_PAR:   txd = cur_q.par_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign hold_empty = !cur_q.hold_full;
    assign tx_empty   = (cur_q.state == ST_IDLE) && !cur_q.hold_full;

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R7
    empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    // R6
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && cur_q.hold_full) |=> (!txd && (hold_empty || $past(wr_en))));

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cur_q.state != ST_IDLE) |=> (cur_q.state == $past(cur_q.state)));

    // R4
    stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_STOP) |-> (cur_q.tcnt <= cur_q.stop_end));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic [DIV_W-1:0]  divisor,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);
    logic tick;

    uftx_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    uftx_serializer #(.DATA_W(DATA_W), .OVS(OVS)) ser_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop2   (cfg_stop2),
        .txd         (txd),
        .hold_empty  (hold_empty),
        .tx_empty    (tx_empty)
    );
endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic [7:0] data;
        int         nbits;
        bit         par_en;
        bit         par_odd;
        int         stop_ticks;
        int         div;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  cfg_wlen = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_stop2 = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic        txd, hold_empty, tx_empty;

    int     n_checks = 0;
    int     n_fail = 0;
    int     cyc = 0;
    bit     mon_en = 1'b1;
    bit     mon_busy = 1'b0;
    frame_t exp_q[$];

    uart_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .divisor(divisor),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        while (cyc < WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
        finish_run();
    end

    // Driver: writes one byte with the given framing, records expected frame.
    task automatic send(input logic [7:0] d, input logic [1:0] wl, input bit pe,
                        input bit po, input bit s2, input int dv);
        frame_t f;
        @(negedge clk);
        cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
        divisor = 16'(dv);
        wr_data = d; wr_en = 1'b1;
        f.data = d; f.nbits = 5 + int'(wl); f.par_en = pe; f.par_odd = po;
        f.stop_ticks = !s2 ? 16 : (wl == 2'd0 ? 24 : 32);
        f.div = dv;
        exp_q.push_back(f);
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty == 1'b0, "R6", "hold_empty after write", int'(hold_empty), 0);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (exp_q.size() != 0 || mon_busy || !tx_empty) @(negedge clk);
    endtask

    // Monitor: pops expected frames and checks the serial line.
    initial begin
        bit start_seen = 1'b0;
        int t0 = 0;
        forever begin
            frame_t f;
            int d, tt, el, ones;
            bit pbit;
            @(negedge clk);
            if (!mon_en || exp_q.size() == 0) continue;
            if (!start_seen) begin
                if (txd !== 1'b0) continue;
                t0 = cyc;
            end
            start_seen = 1'b0;
            mon_busy = 1'b1;
            f = exp_q.pop_front();
            d = f.div;
            repeat (8 * d) @(negedge clk);
            chk(txd == 1'b0, "R1", "start bit level", int'(txd), 0);
            ones = 0;
            for (int i = 0; i < f.nbits; i++) begin
                repeat (16 * d) @(negedge clk);
                ones += int'(f.data[i]);
                chk(txd == f.data[i], "R2", $sformatf("data bit %0d", i), int'(txd), int'(f.data[i]));
            end
            if (f.par_en) begin
                pbit = (ones % 2 == 1) ^ f.par_odd;
                repeat (16 * d) @(negedge clk);
                chk(txd == pbit, "R3", "parity bit", int'(txd), int'(pbit));
            end
            repeat (16 * d) @(negedge clk);
            chk(txd == 1'b1, "R1", "stop level", int'(txd), 1);
            while (tx_empty !== 1'b1 && txd !== 1'b0) @(negedge clk);
            el = cyc - t0;
            tt = 16 * (1 + f.nbits + (f.par_en ? 1 : 0)) + f.stop_ticks;
            chk(el >= (tt - 1) * d && el <= tt * d + 2, "R4", "frame length in clocks", el, tt * d);
            if (txd === 1'b0) begin
                start_seen = 1'b1;
                t0 = cyc;
            end
            mon_busy = 1'b0;
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R9", "txd in reset", int'(txd), 1);
        chk(hold_empty == 1'b1, "R9", "hold_empty in reset", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R9", "tx_empty in reset", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "idle line", int'(txd), 1);

        // R1 R2: 8 data bits, no parity, one stop, divisor 1
        send(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R6", "hold_empty after load", int'(hold_empty), 1);
        chk(tx_empty == 1'b0, "R7", "tx_empty during frame", int'(tx_empty), 0);
        wait_done();
        // R3: 7 bits even parity, divisor 2
        send(8'h5B, 2'd2, 1'b1, 1'b0, 1'b0, 2);
        wait_done();
        // R3 R4 R2: 5 bits odd parity, 1.5 stop, upper bits ignored, divisor 3
        send(8'hF3, 2'd0, 1'b1, 1'b1, 1'b1, 3);
        wait_done();
        // R4: 6 bits, two stop
        send(8'h2E, 2'd1, 1'b0, 1'b0, 1'b1, 2);
        wait_done();
        // R3 R4: 8 bits odd parity two stop
        send(8'hC7, 2'd3, 1'b1, 1'b1, 1'b1, 1);
        wait_done();
        // R3: 6 bits even parity
        send(8'h9D, 2'd1, 1'b1, 1'b0, 1'b0, 1);
        wait_done();

        // R6 R7: back-to-back bytes
        send(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 2);
        send(8'h7E, 2'd3, 1'b0, 1'b0, 1'b0, 2);
        repeat (60) @(negedge clk);
        chk(hold_empty == 1'b0, "R6", "second byte held during frame", int'(hold_empty), 0);
        chk(tx_empty == 1'b0, "R7", "tx_empty with byte held", int'(tx_empty), 0);
        wait_done();
        chk(tx_empty == 1'b1, "R7", "tx_empty after last stop", int'(tx_empty), 1);

        // R8: framing changed mid-frame has no effect
        send(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 2);
        repeat (20) @(negedge clk);
        cfg_wlen = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
        wait_done();

        // R5: divisor zero freezes the frame in its start bit
        mon_en = 1'b0;
        @(negedge clk);
        divisor = 16'd0;
        cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        wr_data = 8'h55; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (300) @(negedge clk);
        chk(txd == 1'b0, "R5", "txd frozen in start bit", int'(txd), 0);
        chk(tx_empty == 1'b0, "R5", "tx_empty while halted", int'(tx_empty), 0);
        divisor = 16'd1;
        t = 0;
        while (!tx_empty && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk(t >= 159 && t <= 162, "R5", "frame resumes after divisor restored", t, 160);
        chk(txd == 1'b1, "R1", "idle after resumed frame", int'(txd), 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule